// File: doc/BRIEF.md
# Supervisor Compacted-Save Fault Classifier

This block decides, for one execution of the privileged compacted state-save operation, which fault the operation must take before any memory is touched. It looks at the feature-support flags, the OS enable bit, the task-switched bit, a LOCK-prefix flag, the current privilege level, the operating mode and the destination address. From these it reports a single fault class. Page-fault detection is not done here. The segment-limit check and the canonical-form check are also done elsewhere, and their results arrive as single-bit inputs.

A request is a one-cycle strobe on `chk_req`. Exactly one cycle later, `flt_vld` pulses for one cycle and `flt_code` carries the verdict. The block accepts a new request on every cycle, and it has no ready signal and no back-pressure: the consumer must take each result in the cycle it is valid. `flt_code` keeps its value until the next request.

Top module: `svsave_flt_chk`

## Requirements
- R1: A request on `chk_req` gives `flt_vld` = 1 on the next clock edge, for that one cycle only. A cycle without a request gives `flt_vld` = 0 on the next edge. After reset, `flt_vld` = 0 and `flt_code` = 0.
- R2: Invalid opcode (code 1) is reported when any of these holds: `feat_xsave` = 0, `feat_sup` = 0, `os_en` = 0, or `lock_pfx` = 1. This fault outranks every other fault.
- R3: Device-not-available (code 2) is reported when `task_sw` = 1 and R2 does not apply.
- R4: In every mode except real-address mode (`mode` = 0), `cpl` not equal to 0 gives general protection (code 3), provided R2 and R3 do not apply. In real-address mode, `cpl` is ignored.
- R5: A destination whose low 6 address bits are not all zero gives general protection (code 3) in every mode.
- R6: In 64-bit mode (`mode` = 4), `canon_ok` = 0 gives stack fault (code 4) when `stack_seg` = 1, and general protection otherwise. In this mode, `lim_ok` is ignored.
- R7: In protected (1), virtual-8086 (2) and compatibility (3) modes, `lim_ok` = 0 gives stack fault when `stack_seg` = 1, and general protection otherwise. In these modes, `canon_ok` is ignored.
- R8: In real-address mode, general protection is reported when the last operand byte, at `addr + op_len - 1`, lies above FFFFh. In this mode, `lim_ok` and `canon_ok` are ignored.
- R9: The alignment check of R5 outranks the canonical and limit checks. A misaligned stack access that also fails its limit therefore gives code 3.
- R10: When no condition holds, the code is 0 (none). The code values are: none 0, invalid opcode 1, device-not-available 2, general protection 3, stack fault 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chk_req | input | 1 | One-cycle check request |
| cpl | input | 2 | Current privilege level |
| mode | input | 3 | Mode: 0 real, 1 protected, 2 virtual-8086, 3 compatibility, 4 64-bit |
| feat_xsave | input | 1 | Base extended-save feature present |
| feat_sup | input | 1 | Supervisor-save feature present |
| os_en | input | 1 | OS has enabled extended-state saving |
| task_sw | input | 1 | Task-switched control bit |
| lock_pfx | input | 1 | LOCK prefix present |
| addr | input | AW | Effective destination address |
| op_len | input | LW | Operand length in bytes (real-mode span) |
| canon_ok | input | 1 | Address is canonical (64-bit mode) |
| lim_ok | input | 1 | Address is within its segment limit |
| stack_seg | input | 1 | Access goes through the stack segment |
| flt_vld | output | 1 | Result valid, one cycle after the request |
| flt_code | output | 3 | Fault class, per R10 |

## Verification
The assertions assume that the inputs are stable and known whenever `chk_req` is high. They also assume that `mode` takes only the five defined values, and that `op_len` does not exceed the address range in real-address mode. The bench drives every input on the falling edge, and it uses only the defined mode codes. It holds all qualifying inputs constant across the request cycle and returns them to a clean state between scenarios, so the properties always see the inputs that produced each result.

// File: rtl/svsave_pkg.sv
package svsave_pkg;
  typedef enum logic [2:0] {
    M_REAL   = 3'd0,
    M_PROT   = 3'd1,
    M_V86    = 3'd2,
    M_COMPAT = 3'd3,
    M_LONG   = 3'd4
  } mode_e;

  typedef enum logic [2:0] {
    F_NONE = 3'd0,
    F_UD   = 3'd1,
    F_NM   = 3'd2,
    F_GP   = 3'd3,
    F_SS   = 3'd4
  } fault_e;
endpackage

// File: rtl/svsave_gate_chk.sv
module svsave_gate_chk
  import svsave_pkg::*;
(
  input  logic [1:0] cpl,
  input  mode_e      mode,
  input  logic       feat_xsave,
  input  logic       feat_sup,
  input  logic       os_en,
  input  logic       task_sw,
  input  logic       lock_pfx,
  output logic       ud_hit,
  output logic       nm_hit,
  output logic       priv_hit
);
  always_comb begin
    ud_hit   = !feat_xsave || !feat_sup || !os_en || lock_pfx;
    nm_hit   = task_sw;
    priv_hit = (mode != M_REAL) && (cpl != 2'd0);
  end
endmodule

// File: rtl/svsave_addr_chk.sv
module svsave_addr_chk
  import svsave_pkg::*;
#(
  parameter int AW        = 64,
  parameter int LW        = 16,
  parameter int ALIGN_LG  = 6,
  parameter int REAL_BITS = 16
) (
  input  mode_e           mode,
  input  logic [AW-1:0]   addr,
  input  logic [LW-1:0]   op_len,
  input  logic            canon_ok,
  input  logic            lim_ok,
  input  logic            stack_seg,
  output fault_e          addr_flt
);
  localparam int SW = AW + 1;

  logic          misalign;
  logic [SW-1:0] last_byte;
  logic          real_over;

  always_comb begin
    misalign  = |addr[ALIGN_LG-1:0];
    last_byte = {1'b0, addr} + {{(SW-LW){1'b0}}, op_len};
    if (op_len != '0) last_byte = last_byte - SW'(1);
    real_over = |last_byte[SW-1:REAL_BITS];
  end

  always_comb begin
    addr_flt = F_NONE;
    if (misalign) begin
      addr_flt = F_GP;
    end else begin
      case (mode)
        M_REAL:  if (real_over) addr_flt = F_GP;
        M_LONG:  if (!canon_ok) addr_flt = stack_seg ? F_SS : F_GP;
        default: if (!lim_ok)   addr_flt = stack_seg ? F_SS : F_GP;
      endcase
    end
  end
endmodule

// File: rtl/svsave_flt_chk.sv
module svsave_flt_chk
  import svsave_pkg::*;
#(
  parameter int AW        = 64,
  parameter int LW        = 16,
  parameter int ALIGN_LG  = 6,
  parameter int REAL_BITS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chk_req,
  input  logic [1:0]    cpl,
  input  logic [2:0]    mode,
  input  logic          feat_xsave,
  input  logic          feat_sup,
  input  logic          os_en,
  input  logic          task_sw,
  input  logic          lock_pfx,
  input  logic [AW-1:0] addr,
  input  logic [LW-1:0] op_len,
  input  logic          canon_ok,
  input  logic          lim_ok,
  input  logic          stack_seg,
  output logic          flt_vld,
  output logic [2:0]    flt_code
);
  mode_e  mode_q;
  logic   ud_hit, nm_hit, priv_hit;
  fault_e addr_flt;
  fault_e verdict;

  assign mode_q = mode_e'(mode);

  svsave_gate_chk u_gate (
    .cpl        (cpl),
    .mode       (mode_q),
    .feat_xsave (feat_xsave),
    .feat_sup   (feat_sup),
    .os_en      (os_en),
    .task_sw    (task_sw),
    .lock_pfx   (lock_pfx),
    .ud_hit     (ud_hit),
    .nm_hit     (nm_hit),
    .priv_hit   (priv_hit)
  );

  svsave_addr_chk #(
    .AW        (AW),
    .LW        (LW),
    .ALIGN_LG  (ALIGN_LG),
    .REAL_BITS (REAL_BITS)
  ) u_addr (
    .mode      (mode_q),
    .addr      (addr),
    .op_len    (op_len),
    .canon_ok  (canon_ok),
    .lim_ok    (lim_ok),
    .stack_seg (stack_seg),
    .addr_flt  (addr_flt)
  );

  always_comb begin
    if (ud_hit)        verdict = F_UD;
    else if (nm_hit)   verdict = F_NM;
    else if (priv_hit) verdict = F_GP;
    else               verdict = addr_flt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_vld  <= 1'b0;
      flt_code <= 3'd0;
    end else begin
      flt_vld <= chk_req;
      if (chk_req) flt_code <= verdict;
    end
  end

  // R1: one result pulse per request, none otherwise
  a_r1_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req |=> flt_vld);
  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_req |=> !flt_vld);

  // R2: lock prefix always yields invalid opcode
  a_r2_lock_ud: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req && lock_pfx |=> flt_code == 3'd1);

  // R3: task-switched with features enabled yields device-not-available
  a_r3_ts_nm: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req && task_sw && feat_xsave && feat_sup && os_en && !lock_pfx
    |=> flt_code == 3'd2);

  // R5, R9: misaligned destination past the first two gates is general protection
  a_r9_align_first: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req && feat_xsave && feat_sup && os_en && !lock_pfx && !task_sw
    && (addr[ALIGN_LG-1:0] != '0) |=> flt_code == 3'd3);

  // R8: real-address mode never produces a stack fault
  a_r8_real_no_ss: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req && mode == 3'd0 |=> flt_code != 3'd4);

  // R10: only defined codes appear
  a_r10_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    flt_vld |-> flt_code <= 3'd4);
endmodule

// File: tb/svsave_flt_chk_bench.sv
module svsave_flt_chk_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 64;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          chk_req = 1'b0;
  logic [1:0]    cpl = 2'd0;
  logic [2:0]    mode = 3'd1;
  logic          feat_xsave = 1'b1, feat_sup = 1'b1, os_en = 1'b1;
  logic          task_sw = 1'b0, lock_pfx = 1'b0;
  logic [AW-1:0] addr = 64'h1000;
  logic [LW-1:0] op_len = 16'd64;
  logic          canon_ok = 1'b1, lim_ok = 1'b1, stack_seg = 1'b0;
  logic          flt_vld;
  logic [2:0]    flt_code;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  svsave_flt_chk u_svsave_flt_chk (
    .clk(clk), .rst_n(rst_n), .chk_req(chk_req), .cpl(cpl), .mode(mode),
    .feat_xsave(feat_xsave), .feat_sup(feat_sup), .os_en(os_en),
    .task_sw(task_sw), .lock_pfx(lock_pfx), .addr(addr), .op_len(op_len),
    .canon_ok(canon_ok), .lim_ok(lim_ok), .stack_seg(stack_seg),
    .flt_vld(flt_vld), .flt_code(flt_code)
  );

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clean();
    cpl = 2'd0; mode = 3'd1; feat_xsave = 1'b1; feat_sup = 1'b1; os_en = 1'b1;
    task_sw = 1'b0; lock_pfx = 1'b0; addr = 64'h1000; op_len = 16'd64;
    canon_ok = 1'b1; lim_ok = 1'b1; stack_seg = 1'b0;
  endtask

  // issue at negedge, sample at next negedge, then confirm the pulse ends
  task automatic fire(input logic [2:0] exp, input string tag);
    chk_req = 1'b1;
    @(negedge clk);
    chk_req = 1'b0;
    chk({3'd0, flt_vld}, 4'd1, {tag, " R1 vld"});
    chk({1'b0, flt_code}, {1'b0, exp}, tag);
    @(negedge clk);
    chk({3'd0, flt_vld}, 4'd0, {tag, " R1 drop"});
    clean();
  endtask

  task automatic t_reset();
    chk({3'd0, flt_vld}, 4'd0, "R1 reset vld");
    chk({1'b0, flt_code}, 4'd0, "R1 reset code");
  endtask

  task automatic t_clean();
    fire(3'd0, "R10 prot clean");
    mode = 3'd4; fire(3'd0, "R10 long clean");
    mode = 3'd0; addr = 64'h40; fire(3'd0, "R10 real clean");
  endtask

  task automatic t_ud();
    feat_xsave = 1'b0; task_sw = 1'b1; cpl = 2'd3; fire(3'd1, "R2 base feat");
    feat_sup = 1'b0; addr = 64'h1004; fire(3'd1, "R2 sup feat");
    os_en = 1'b0; fire(3'd1, "R2 os enable");
    lock_pfx = 1'b1; mode = 3'd4; canon_ok = 1'b0; fire(3'd1, "R2 lock");
  endtask

  task automatic t_nm();
    task_sw = 1'b1; cpl = 2'd3; addr = 64'h1001; fire(3'd2, "R3 ts");
  endtask

  task automatic t_priv();
    cpl = 2'd3; mode = 3'd2; fire(3'd3, "R4 v86 cpl3");
    cpl = 2'd1; mode = 3'd4; fire(3'd3, "R4 long cpl1");
    cpl = 2'd3; mode = 3'd0; addr = 64'h80; fire(3'd0, "R4 real cpl ignored");
  endtask

  task automatic t_align();
    addr = 64'h1008; fire(3'd3, "R5 prot");
    mode = 3'd4; addr = 64'h1020; fire(3'd3, "R5 long");
    mode = 3'd0; addr = 64'h0001; fire(3'd3, "R5 real");
  endtask

  task automatic t_long();
    mode = 3'd4; canon_ok = 1'b0; stack_seg = 1'b1; fire(3'd4, "R6 ss");
    mode = 3'd4; canon_ok = 1'b0; fire(3'd3, "R6 gp");
    mode = 3'd4; lim_ok = 1'b0; stack_seg = 1'b1; fire(3'd0, "R6 limit ignored");
  endtask

  task automatic t_lim();
    lim_ok = 1'b0; stack_seg = 1'b1; fire(3'd4, "R7 prot ss");
    mode = 3'd3; lim_ok = 1'b0; fire(3'd3, "R7 compat gp");
    mode = 3'd2; lim_ok = 1'b0; stack_seg = 1'b1; fire(3'd4, "R7 v86 ss");
    canon_ok = 1'b0; stack_seg = 1'b1; fire(3'd0, "R7 canon ignored");
  endtask

  task automatic t_real();
    mode = 3'd0; addr = 64'hFFC0; fire(3'd0, "R8 ends at FFFF");
    mode = 3'd0; addr = 64'hFFC0; op_len = 16'd65; fire(3'd3, "R8 past FFFF");
    mode = 3'd0; lim_ok = 1'b0; canon_ok = 1'b0; stack_seg = 1'b1;
    fire(3'd0, "R8 limit canon ignored");
  endtask

  task automatic t_order();
    addr = 64'h1010; lim_ok = 1'b0; stack_seg = 1'b1; fire(3'd3, "R9 prot");
    mode = 3'd4; addr = 64'h1010; canon_ok = 1'b0; stack_seg = 1'b1;
    fire(3'd3, "R9 long");
  endtask

  task automatic t_idle();
    repeat (3) @(negedge clk);
    chk({3'd0, flt_vld}, 4'd0, "R1 idle");
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_clean();
    t_ud();
    t_nm();
    t_priv();
    t_align();
    t_long();
    t_lim();
    t_real();
    t_order();
    t_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule